// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit interval counters behind a byte-wide register interface with a 2-bit address. Offsets 0 to 2 reach each channel's count. Offset 3 takes control words, which configure a channel, freeze its count for later reading, or capture several channels' counts and status bytes at once. Every channel follows a shared count-enable strobe. It applies one of six output rules to the number of strobes it has seen since its last restart, and it drives one output pin.

A restart happens when a count is loaded. In some modes a rising gate edge also causes one. A count of up to two bytes can be written in low-only, high-only or low-then-high order, and it is read back in the same order. The status of channel 2 is also placed on a small speaker status byte, together with a speaker-enable input and a free-running refresh toggle. The BCD flag is stored and reported but does not change the counting.

Top module: `itv_timer`

## Requirements
- R1: After reset each channel is unconfigured, with its output low, word access, mode field 0, BCD 0 and count 65536. A read-back status of such a channel returns 0x30.
- R2: A control word at offset 3 is decoded as channel in [7:6], access in [5:4], mode in [3:1] and BCD in [0]. Access 0 latches that channel's count and leaves its configuration unchanged. Access 1 (low byte), 2 (high byte) or 3 (low then high) sets the access mode and restarts both byte sequences.
- R3: Mode codes 6 and 7 are stored and behave as modes 2 and 3.
- R4: A count load restarts the channel. A written count of 0 means 65536. The readable count is (count - elapsed) mod 65536 in modes 0, 1, 4 and 5, and (count - phase) in modes 2 and 3, where phase = elapsed mod count.
- R5: Mode 0 drives the output high once elapsed >= count. Mode 1 drives it high while elapsed < count.
- R6: Modes 4 and 5 drive the output high only while elapsed == count.
- R7: Mode 2 drives the output high when phase == 0 and elapsed != 0. Mode 3 drives it high while phase < (count+1)/2.
- R8: A rising gate edge restarts the channel in modes 1, 2, 3 and 5. It has no effect in modes 0 and 4.
- R9: A read-back control word has [7:6]=3, with bits 1, 2 and 3 selecting channels 0, 1 and 2. With bit 5 clear it latches the selected counts. With bit 4 clear it latches the selected statuses.
- R10: The status byte is {output, 0, access[1:0], mode[2:0], BCD}. A latched status is returned by the next read ahead of a latched count, and that read clears it. A latched count or status is not replaced until it has been read out.
- R11: A latched count is returned low byte then high byte in word access, and as one byte in low-only or high-only access. Live reads in word access alternate low and high. Reads at offset 3 return 0x00 and change nothing.
- R12: In word access the first count byte is only staged. The count is loaded, and the channel restarted, only when the second byte arrives.
- R13: spk_o carries channel 2's registered gate in bit 0, spk_en_i in bit 1, a toggle that flips every REFRESH_DIV clocks in bit 4, and channel 2's output in bit 5. Its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe shared by all channels |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; the read consumes rdata_o at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed offset |
| gate_i | input | 3 | Per-channel gate |
| out_o | output | 3 | Per-channel output |
| spk_en_i | input | 1 | Speaker data enable, reported on spk_o |
| spk_o | output | 8 | Speaker status byte |

## Verification
The bench builds the block with REFRESH_DIV set to 4. This lets the refresh toggle be seen flipping within a few clocks, instead of after the default divider's longer period. The counter width stays at its 16 bits. That keeps the zero-means-65536 load and the wrap of the readable count from 0x0000 to 0xFFFF within reach after a single strobe. The test counts are kept small so that every modulo, half-period and gate-restart case is reached in a handful of strobes.

// File: rtl/itv_pkg.sv
package itv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    LAT_NONE = 2'd0,
    LAT_LO   = 2'd1,
    LAT_HI   = 2'd2,
    LAT_WORD = 2'd3
  } lat_e;

  localparam logic [2:0] MODE_0 = 3'd0;
  localparam logic [2:0] MODE_1 = 3'd1;
  localparam logic [2:0] MODE_2 = 3'd2;
  localparam logic [2:0] MODE_3 = 3'd3;
  localparam logic [2:0] MODE_4 = 3'd4;
  localparam logic [2:0] MODE_5 = 3'd5;
endpackage

// File: rtl/itv_core.sv
module itv_core
  import itv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_valid_i,
  input  logic [2:0]       mode_i,
  input  logic             load_i,
  input  logic [CNT_W:0]   load_val_i,
  input  logic             gate_i,
  output logic             out_o,
  output logic             gate_o,
  output logic [CNT_W-1:0] cur_cnt_o
);
  localparam int EW = CNT_W + 1;
  localparam logic [EW-1:0] E_MAX  = '1;
  localparam logic [EW-1:0] E_FULL = EW'(1) << CNT_W;

  logic          gate_q;
  logic [EW-1:0] count_q, elap_q, phase_q;
  logic [EW-1:0] phase_nxt, diff;
  logic [EW:0]   half;
  logic          gate_rise, gate_mode, restart, periodic;

  assign gate_rise = gate_i & ~gate_q;
  assign gate_mode = (mode_i == MODE_1) || (mode_i == MODE_2) ||
                     (mode_i == MODE_3) || (mode_i == MODE_5);
  assign restart   = load_i | (gate_rise & gate_mode & cfg_valid_i);
  assign phase_nxt = phase_q + EW'(1);
  assign periodic  = (mode_i == MODE_2) || (mode_i == MODE_3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      count_q <= E_FULL;
      elap_q  <= '0;
      phase_q <= '0;
    end else begin
      gate_q <= gate_i;
      if (load_i) count_q <= load_val_i;
      if (restart) begin
        elap_q  <= '0;
        phase_q <= '0;
      end else if (tick_i) begin
        if (elap_q != E_MAX) elap_q <= elap_q + EW'(1);
        phase_q <= (phase_nxt == count_q) ? '0 : phase_nxt;
      end
    end
  end

  assign half = ({1'b0, count_q} + (EW+1)'(1)) >> 1;

  always_comb begin
    out_o = 1'b0;
    if (cfg_valid_i) begin
      unique case (mode_i)
        MODE_0:  out_o = (elap_q >= count_q);
        MODE_1:  out_o = (elap_q < count_q);
        MODE_2:  out_o = (phase_q == '0) && (elap_q != '0);
        MODE_3:  out_o = ({1'b0, phase_q} < half);
        default: out_o = (elap_q == count_q);
      endcase
    end
  end

  assign diff      = count_q - (periodic ? phase_q : elap_q);
  assign cur_cnt_o = diff[CNT_W-1:0];
  assign gate_o    = gate_q;

  AST_MODE1_LOAD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && cfg_valid_i && mode_i == MODE_1 |=> out_o); // R5
  AST_MODE0_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && mode_i == MODE_0 && out_o && !load_i |=> out_o || mode_i != MODE_0); // R5
  AST_MODE4_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && mode_i == MODE_4 && out_o && tick_i && !load_i |=> !out_o || mode_i != MODE_4); // R6
  AST_MODE2_LOAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && cfg_valid_i && mode_i == MODE_2 |=> !out_o); // R7
endmodule

// File: rtl/itv_port.sv
module itv_port
  import itv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              latch_cnt_i,
  input  logic              latch_sts_i,
  input  logic              wr_cnt_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cur_cnt_i,
  input  logic              out_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              cfg_valid_o,
  output logic [2:0]        mode_o,
  output logic              load_o,
  output logic [CNT_W:0]    load_val_o
);
  acc_e              rw_q;
  lat_e              lat_q;
  logic [2:0]        mode_q, mode_fold;
  logic              bcd_q, cfg_q, wr_hi_q, rd_hi_q, sts_lat_q;
  logic [BYTE_W-1:0] stage_q, sts_q;
  logic [CNT_W-1:0]  lat_val_q, raw;

  assign mode_fold = (wdata_i[3] & wdata_i[2]) ? wdata_i[3:1] - 3'd4 : wdata_i[3:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q      <= ACC_WORD;
      lat_q     <= LAT_NONE;
      mode_q    <= MODE_0;
      bcd_q     <= 1'b0;
      cfg_q     <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      sts_lat_q <= 1'b0;
      stage_q   <= '0;
      sts_q     <= '0;
      lat_val_q <= '0;
    end else begin
      if (ctl_we_i) begin
        rw_q    <= acc_e'(wdata_i[5:4]);
        mode_q  <= mode_fold;
        bcd_q   <= wdata_i[0];
        cfg_q   <= 1'b1;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (latch_cnt_i && lat_q == LAT_NONE) begin
        lat_q     <= lat_e'(rw_q);
        lat_val_q <= cur_cnt_i;
      end
      if (latch_sts_i && !sts_lat_q) begin
        sts_lat_q <= 1'b1;
        sts_q     <= {out_i, 1'b0, rw_q, mode_q, bcd_q};
      end
      if (wr_cnt_i && rw_q == ACC_WORD) begin
        if (!wr_hi_q) stage_q <= wdata_i;
        wr_hi_q <= ~wr_hi_q;
      end
      if (rd_i) begin
        if (sts_lat_q) begin
          sts_lat_q <= 1'b0;
        end else if (lat_q != LAT_NONE) begin
          lat_q <= (lat_q == LAT_WORD) ? LAT_HI : LAT_NONE;
        end else if (rw_q == ACC_WORD) begin
          rd_hi_q <= ~rd_hi_q;
        end
      end
    end
  end

  always_comb begin
    if (sts_lat_q) begin
      rdata_o = sts_q;
    end else if (lat_q != LAT_NONE) begin
      rdata_o = (lat_q == LAT_HI) ? lat_val_q[CNT_W-1:BYTE_W] : lat_val_q[BYTE_W-1:0];
    end else begin
      unique case (rw_q)
        ACC_HI:   rdata_o = cur_cnt_i[CNT_W-1:BYTE_W];
        ACC_WORD: rdata_o = rd_hi_q ? cur_cnt_i[CNT_W-1:BYTE_W] : cur_cnt_i[BYTE_W-1:0];
        default:  rdata_o = cur_cnt_i[BYTE_W-1:0];
      endcase
    end
  end

  always_comb begin
    load_o = wr_cnt_i;
    raw    = {{BYTE_W{1'b0}}, wdata_i};
    unique case (rw_q)
      ACC_HI:   raw = {wdata_i, {BYTE_W{1'b0}}};
      ACC_WORD: begin
        raw    = {wdata_i, stage_q};
        load_o = wr_cnt_i & wr_hi_q;
      end
      default: ;
    endcase
  end

  assign load_val_o  = (raw == '0) ? ((CNT_W+1)'(1) << CNT_W) : {1'b0, raw};
  assign cfg_valid_o = cfg_q;
  assign mode_o      = mode_q;

  AST_LATCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q != LAT_NONE && !rd_i |=> $stable(lat_val_q) && lat_q != LAT_NONE); // R10
  AST_STS_BEFORE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && sts_lat_q |=> $stable(lat_q)); // R10
  AST_STS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_lat_q && !rd_i |=> $stable(sts_q) && sts_lat_q); // R10
  AST_STAGE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i && rw_q == ACC_WORD && !ctl_we_i |=> wr_hi_q != $past(wr_hi_q)); // R12
endmodule

// File: rtl/itv_refresh.sv
module itv_refresh #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tog_o
);
  localparam int DW = $clog2(DIV + 1);
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;
  logic          tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + DW'(1);
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/itv_timer.sv
module itv_timer
  import itv_pkg::*;
#(
  parameter int REFRESH_DIV = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] gate_i,
  output logic [NUM_CH-1:0] out_o,
  input  logic              spk_en_i,
  output logic [BYTE_W-1:0] spk_o
);
  localparam logic [1:0] CTL_ADDR = 2'd3;

  logic              wr_ctl, rd_ok, is_rb, refresh;
  logic [NUM_CH-1:0] ctl_we, latch_cnt, latch_sts, wr_cnt, rd_ch, gate_q;
  logic [BYTE_W-1:0] ch_rdata [NUM_CH];

  assign wr_ctl = wr_i && (addr_i == CTL_ADDR);
  assign rd_ok  = rd_i && !wr_i;
  assign is_rb  = (wdata_i[7:6] == 2'b11);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic             sel, cfg_valid, load;
    logic [2:0]       mode;
    logic [CNT_W:0]   load_val;
    logic [CNT_W-1:0] cur_cnt;

    assign sel          = (wdata_i[7:6] == 2'(i));
    assign ctl_we[i]    = wr_ctl && !is_rb && sel && (wdata_i[5:4] != 2'b00);
    assign latch_cnt[i] = wr_ctl && (is_rb ? (!wdata_i[5] && wdata_i[i+1])
                                           : (sel && wdata_i[5:4] == 2'b00));
    assign latch_sts[i] = wr_ctl && is_rb && !wdata_i[4] && wdata_i[i+1];
    assign wr_cnt[i]    = wr_i && (addr_i == 2'(i));
    assign rd_ch[i]     = rd_ok && (addr_i == 2'(i));

    itv_port u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctl_we_i    (ctl_we[i]),
      .latch_cnt_i (latch_cnt[i]),
      .latch_sts_i (latch_sts[i]),
      .wr_cnt_i    (wr_cnt[i]),
      .rd_i        (rd_ch[i]),
      .wdata_i     (wdata_i),
      .cur_cnt_i   (cur_cnt),
      .out_i       (out_o[i]),
      .rdata_o     (ch_rdata[i]),
      .cfg_valid_o (cfg_valid),
      .mode_o      (mode),
      .load_o      (load),
      .load_val_o  (load_val)
    );

    itv_core u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .cfg_valid_i (cfg_valid),
      .mode_i      (mode),
      .load_i      (load),
      .load_val_i  (load_val),
      .gate_i      (gate_i[i]),
      .out_o       (out_o[i]),
      .gate_o      (gate_q[i]),
      .cur_cnt_o   (cur_cnt)
    );
  end

  itv_refresh #(.DIV(REFRESH_DIV)) u_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tog_o  (refresh)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == 2'(i)) rdata_o = ch_rdata[i];
  end

  assign spk_o = {2'b00, out_o[2], refresh, 2'b00, spk_en_i, gate_q[2]};

  AST_CTL_ONE_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctl_we) && !(|(ctl_we & latch_cnt))); // R2
  AST_SPK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> spk_o[0] == $past(gate_i[2])); // R13
endmodule

// File: tb/itv_timer_tb.sv
module itv_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] gate = '0;
  logic [2:0] out;
  logic       spk_en = 1'b0;
  logic [7:0] spk;

  int  errs = 0;
  int  checks = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  itv_timer #(.REFRESH_DIV(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .gate_i(gate), .out_o(out),
    .spk_en_i(spk_en), .spk_o(spk)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    chk(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic tk(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic out_chk(input string req, input int ch, input logic exp);
    #1 chk(req, {15'h0, out[ch]}, {15'h0, exp});
  endtask

  task automatic gate_pulse(input int ch);
    @(negedge clk); gate[ch] = 1'b1;
    @(negedge clk); gate[ch] = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R1 outputs", {13'h0, out}, 16'h0);
    chk("R1 speaker", {8'h00, spk & 8'hEF}, 16'h0);
    bus_wr(2'd3, 8'hE2);
    rd_chk("R1 status", 2'd0, 8'h30);
  endtask

  task automatic t_mode01();
    bus_wr(2'd3, 8'h30); bus_wr(2'd0, 8'd5); bus_wr(2'd0, 8'd0);
    out_chk("R5 mode0 start", 0, 1'b0);
    tk(2); bus_wr(2'd3, 8'h00);
    tk(2); out_chk("R5 mode0 below", 0, 1'b0);
    rd_chk("R11 latched lo", 2'd0, 8'd3);
    rd_chk("R11 latched hi", 2'd0, 8'd0);
    tk(1); out_chk("R5 mode0 reached", 0, 1'b1);
    bus_wr(2'd3, 8'hB2); bus_wr(2'd2, 8'd3); bus_wr(2'd2, 8'd0);
    out_chk("R5 mode1 start", 2, 1'b1);
    tk(2); out_chk("R5 mode1 running", 2, 1'b1);
    tk(1); out_chk("R5 mode1 end", 2, 1'b0);
  endtask

  task automatic t_gate();
    @(negedge clk); gate[2] = 1'b1;
    @(negedge clk);
    out_chk("R8 mode1 restart", 2, 1'b1);
    chk("R13 gate bit", {15'h0, spk[0]}, 16'h1);
    chk("R13 out bit", {15'h0, spk[5]}, 16'h1);
    gate[2] = 1'b0;
    gate_pulse(0);
    out_chk("R8 mode0 no restart", 0, 1'b1);
  endtask

  task automatic t_zero();
    bus_wr(2'd3, 8'h70); bus_wr(2'd1, 8'd0); bus_wr(2'd1, 8'd0);
    bus_wr(2'd3, 8'h40);
    rd_chk("R4 zero lo", 2'd1, 8'h00);
    rd_chk("R4 zero hi", 2'd1, 8'h00);
    tk(1); bus_wr(2'd3, 8'h40);
    rd_chk("R4 wrap lo", 2'd1, 8'hFF);
    rd_chk("R4 wrap hi", 2'd1, 8'hFF);
    out_chk("R4 out low", 1, 1'b0);
  endtask

  task automatic t_mode45();
    bus_wr(2'd3, 8'h78); bus_wr(2'd1, 8'd3); bus_wr(2'd1, 8'd0);
    tk(2); out_chk("R6 mode4 before", 1, 1'b0);
    tk(1); out_chk("R6 mode4 equal", 1, 1'b1);
    tk(1); out_chk("R6 mode4 after", 1, 1'b0);
    bus_wr(2'd3, 8'h7A); bus_wr(2'd1, 8'd2); bus_wr(2'd1, 8'd0);
    tk(2); out_chk("R6 mode5 equal", 1, 1'b1);
    tk(1); out_chk("R6 mode5 after", 1, 1'b0);
    gate_pulse(1);
    tk(2); out_chk("R8 mode5 restart", 1, 1'b1);
  endtask

  task automatic t_mode23();
    bus_wr(2'd3, 8'h34); bus_wr(2'd0, 8'd3); bus_wr(2'd0, 8'd0);
    out_chk("R7 mode2 start", 0, 1'b0);
    tk(2); out_chk("R7 mode2 mid", 0, 1'b0);
    tk(1); out_chk("R7 mode2 pulse", 0, 1'b1);
    tk(1); out_chk("R7 mode2 drop", 0, 1'b0);
    tk(2); out_chk("R7 mode2 second", 0, 1'b1);
    bus_wr(2'd3, 8'h36); bus_wr(2'd0, 8'd5); bus_wr(2'd0, 8'd0);
    out_chk("R7 mode3 start", 0, 1'b1);
    tk(2); out_chk("R7 mode3 high", 0, 1'b1);
    tk(1); out_chk("R7 mode3 low", 0, 1'b0);
    tk(1); out_chk("R7 mode3 low2", 0, 1'b0);
    tk(1); out_chk("R7 mode3 wrap", 0, 1'b1);
    rd_chk("R11 live lo", 2'd0, 8'd5);
    rd_chk("R11 live hi", 2'd0, 8'd0);
  endtask

  task automatic t_fold();
    bus_wr(2'd3, 8'hBF); bus_wr(2'd2, 8'd4); bus_wr(2'd2, 8'd0);
    out_chk("R3 mode7 as 3", 2, 1'b1);
    bus_wr(2'd3, 8'hE8);
    rd_chk("R3 status", 2'd2, 8'hB7);
    rd_chk("R10 status cleared", 2'd2, 8'd4);
  endtask

  task automatic t_readback();
    bus_wr(2'd3, 8'h70); bus_wr(2'd1, 8'd10); bus_wr(2'd1, 8'd0);
    bus_wr(2'd3, 8'h30); bus_wr(2'd0, 8'd20); bus_wr(2'd0, 8'd0);
    tk(2); bus_wr(2'd3, 8'hD2);
    tk(1);
    rd_chk("R9 unselected lo", 2'd1, 8'd7);
    rd_chk("R9 unselected hi", 2'd1, 8'd0);
    rd_chk("R9 selected lo", 2'd0, 8'd18);
    rd_chk("R9 selected hi", 2'd0, 8'd0);
    bus_wr(2'd3, 8'hC4);
    tk(1);
    bus_wr(2'd3, 8'h40);
    bus_wr(2'd3, 8'hE4);
    rd_chk("R10 status first", 2'd1, 8'h30);
    rd_chk("R10 held lo", 2'd1, 8'd7);
    rd_chk("R10 held hi", 2'd1, 8'd0);
    rd_chk("R10 live after", 2'd1, 8'd6);
  endtask

  task automatic t_bytes();
    bus_wr(2'd3, 8'h50); bus_wr(2'd1, 8'd9);
    rd_chk("R11 lo only", 2'd1, 8'd9);
    rd_chk("R11 lo only again", 2'd1, 8'd9);
    rd_chk("R11 addr3 read", 2'd3, 8'h00);
    rd_chk("R11 after addr3", 2'd1, 8'd9);
    bus_wr(2'd3, 8'h60); bus_wr(2'd1, 8'h02);
    rd_chk("R11 hi only", 2'd1, 8'h02);
    bus_wr(2'd3, 8'h40);
    tk(1);
    rd_chk("R11 hi latched", 2'd1, 8'h02);
    rd_chk("R11 hi live", 2'd1, 8'h01);
  endtask

  task automatic t_stage();
    bus_wr(2'd3, 8'h30); bus_wr(2'd0, 8'd6); bus_wr(2'd0, 8'd0);
    tk(2); bus_wr(2'd0, 8'd9);
    tk(4); out_chk("R12 staged no load", 0, 1'b1);
    bus_wr(2'd0, 8'd0);
    out_chk("R12 loaded", 0, 1'b0);
    tk(8); out_chk("R12 new count below", 0, 1'b0);
    tk(1); out_chk("R12 new count reached", 0, 1'b1);
  endtask

  task automatic t_spk();
    logic a, b;
    @(negedge clk); spk_en = 1'b1;
    #1 chk("R13 enable bit", {15'h0, spk[1]}, 16'h1);
    chk("R13 zero bits", {8'h00, spk & 8'hCC}, 16'h0);
    a = spk[4];
    repeat (4) @(negedge clk);
    #1 b = spk[4];
    chk("R13 refresh toggles", {15'h0, b}, {15'h0, ~a});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode01();
    t_gate();
    t_zero();
    t_mode45();
    t_mode23();
    t_fold();
    t_readback();
    t_bytes();
    t_stage();
    t_spk();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule